// File: doc/BRIEF.md
# Counter-Based Pulse Generator

This block produces a rectangular pulse train. Both the repetition interval and the high time are whole numbers of generation-clock cycles. Two reloadable down-counters do the timing. The period counter reloads itself every interval and emits a rising-edge event each time it wraps. That event sets an output flip-flop and restarts the width counter. When the width counter runs out it emits a falling-edge event, and that event clears the flip-flop. The resolution of both the period and the width is therefore one clock cycle.

The interval and the high time are two independent control words, sampled only at the moment a pulse begins. Software may rewrite them at any time without distorting a pulse already in flight. Illegal combinations are clamped so the output can never stay high forever. Besides the pulse level, the block gives two one-cycle strobes that mark the first high cycle and the first low cycle of each pulse.

All pins are plain control or status levels. There is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `cyc_pulse_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with `run_en` low, `pulse_out`, `rise_stb` and `fall_stb` are all 0.
- R2: When `run_en` is sampled high at a clock edge after a cycle in which the block was idle, `pulse_out` and `rise_stb` are 1 in the cycle that follows that edge.
- R3: With a constant effective period P (P ≥ 2), `rise_stb` is 1 exactly once every P cycles, starting with the first rising edge.
- R4: With a constant effective width W, `pulse_out` stays 1 for exactly W cycles from each rising edge and is 0 for the remaining P−W cycles.
- R5: `fall_stb` is 1 for exactly one cycle, in the first cycle after the pulse goes low. That cycle lies W cycles after `rise_stb`.
- R6: `rise_stb` lasts one cycle and coincides with the first high cycle of each pulse.
- R7: The effective width is clamped. A `width_cyc` of 0 is used as 1, and a `width_cyc` of P or more is used as P−1.
- R8: The effective period is clamped. A `period_cyc` of 0 or 1 is used as 2.
- R9: `period_cyc` and `width_cyc` are sampled only at a rising edge. A change made during a pulse leaves that pulse's high time and interval as they were, and applies from the next rising edge.
- R10: When `run_en` is sampled low, the following cycle has `pulse_out` at 0 and both strobes at 0, including when a pulse was in progress. In that case no `fall_stb` is produced. When `run_en` goes high again, the train restarts from a fresh rising edge under R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Generation clock; all timing is counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | High to generate the pulse train; low forces the output low and idles the counters |
| period_cyc | input | CNT_W | Requested repetition interval in cycles |
| width_cyc | input | CNT_W | Requested high time in cycles |
| pulse_out | output | 1 | Pulse level |
| rise_stb | output | 1 | One-cycle strobe in the first high cycle of each pulse |
| fall_stb | output | 1 | One-cycle strobe in the first low cycle after each pulse |

## Verification
The hardest case to reach from the ports is a control word rewritten while a pulse is already high. The check must show that the running high time and interval follow the old values, and that the new ones appear exactly at the next rising edge. The stimulus changes both words on the falling clock edge right after `rise_stb` is seen. The expected waveform is then predicted in two segments, split at the first rising edge that follows. A second hard case is dropping `run_en` partway through a high phase. The bench checks that the pulse falls with no `fall_stb`, and that the next rising edge comes on the first cycle after re-enable.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

  // Shortest interval that still leaves a low phase after a one-cycle pulse.
  parameter int CPG_MIN_PERIOD = 2;

  // Action applied to the output flip-flop at each clock edge.
  typedef enum logic [1:0] {
    CPG_HOLD = 2'd0,
    CPG_SET  = 2'd1,
    CPG_CLR  = 2'd2,
    CPG_OFF  = 2'd3
  } cpg_action_e;

endpackage

// File: rtl/cpg_limit.sv
module cpg_limit #(
  parameter int CNT_W = 32
) (
  input  logic [CNT_W-1:0] period_req,
  input  logic [CNT_W-1:0] width_req,
  output logic [CNT_W-1:0] period_eff,
  output logic [CNT_W-1:0] width_eff
);
  import cpg_pkg::*;

  localparam logic [CNT_W-1:0] MIN_P = CNT_W'(CPG_MIN_PERIOD);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  // Period floor first, because the width ceiling depends on it.
  always_comb begin
    if (period_req < MIN_P) period_eff = MIN_P;
    else                    period_eff = period_req;
  end

  always_comb begin
    if (width_req == '0)              width_eff = ONE;
    else if (width_req >= period_eff) width_eff = period_eff - ONE;
    else                              width_eff = width_req;
  end

endmodule

// File: rtl/cpg_period_ctr.sv
module cpg_period_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [CNT_W-1:0] period_eff,
  output logic             lead_ev
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  // A rising edge fires on the first enabled cycle, then whenever the count wraps.
  assign lead_ev = run_en && (!active_q || (cnt_q == ONE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!run_en) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (lead_ev) begin
      active_q <= 1'b1;
      cnt_q    <= period_eff;
    end else if (active_q) begin
      cnt_q    <= cnt_q - ONE;
    end
  end

  AST_PERIOD_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q != '0)); // R3

  AST_LEAD_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    lead_ev |=> !lead_ev); // R8

endmodule

// File: rtl/cpg_width_ctr.sv
module cpg_width_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             lead_ev,
  input  logic [CNT_W-1:0] width_eff,
  output logic             trail_ev
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign trail_ev = run_en && busy_q && (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!run_en) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (lead_ev) begin
      busy_q <= 1'b1;
      cnt_q  <= width_eff;
    end else if (trail_ev) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - ONE;
    end
  end

  AST_WIDTH_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0)); // R4

  AST_EDGES_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(trail_ev && lead_ev)); // R7

endmodule

// File: rtl/cpg_out_ff.sv
module cpg_out_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic lead_ev,
  input  logic trail_ev,
  output logic pulse_out,
  output logic rise_stb,
  output logic fall_stb
);
  import cpg_pkg::*;

  cpg_action_e act;

  always_comb begin
    if (!run_en)       act = CPG_OFF;
    else if (lead_ev)  act = CPG_SET;
    else if (trail_ev) act = CPG_CLR;
    else               act = CPG_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_out <= 1'b0;
      rise_stb  <= 1'b0;
      fall_stb  <= 1'b0;
    end else begin
      rise_stb <= (act == CPG_SET);
      fall_stb <= (act == CPG_CLR);
      case (act)
        CPG_SET:  pulse_out <= 1'b1;
        CPG_CLR:  pulse_out <= 1'b0;
        CPG_OFF:  pulse_out <= 1'b0;
        default:  pulse_out <= pulse_out;
      endcase
    end
  end

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> !rise_stb); // R6

  AST_RISE_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_out) |-> rise_stb); // R2

  AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (!pulse_out && $past(pulse_out))); // R5

  AST_DISABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run_en) |-> (!pulse_out && !rise_stb && !fall_stb)); // R10

endmodule

// File: rtl/cyc_pulse_gen.sv
module cyc_pulse_gen #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [CNT_W-1:0] period_cyc,
  input  logic [CNT_W-1:0] width_cyc,
  output logic             pulse_out,
  output logic             rise_stb,
  output logic             fall_stb
);

  logic [CNT_W-1:0] period_eff;
  logic [CNT_W-1:0] width_eff;
  logic             lead_ev;
  logic             trail_ev;

  cpg_limit #(.CNT_W(CNT_W)) u_limit (
    .period_req (period_cyc),
    .width_req  (width_cyc),
    .period_eff (period_eff),
    .width_eff  (width_eff)
  );

  cpg_period_ctr #(.CNT_W(CNT_W)) u_period (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .period_eff (period_eff),
    .lead_ev    (lead_ev)
  );

  cpg_width_ctr #(.CNT_W(CNT_W)) u_width (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .lead_ev    (lead_ev),
    .width_eff  (width_eff),
    .trail_ev   (trail_ev)
  );

  cpg_out_ff u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .lead_ev    (lead_ev),
    .trail_ev   (trail_ev),
    .pulse_out  (pulse_out),
    .rise_stb   (rise_stb),
    .fall_stb   (fall_stb)
  );

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb)); // R7

  AST_CLAMP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (width_eff != '0) && (width_eff < period_eff)); // R7

endmodule

// File: tb/tb_cyc_pulse_gen.sv
module tb_cyc_pulse_gen;

  localparam int CNT_W = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             run_en = 1'b0;
  logic [CNT_W-1:0] period_cyc = '0;
  logic [CNT_W-1:0] width_cyc = '0;
  logic             pulse_out;
  logic             rise_stb;
  logic             fall_stb;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  cyc_pulse_gen #(.CNT_W(CNT_W)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .period_cyc (period_cyc),
    .width_cyc  (width_cyc),
    .pulse_out  (pulse_out),
    .rise_stb   (rise_stb),
    .fall_stb   (fall_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff_p(input int p);
    return (p < 2) ? 2 : p;
  endfunction

  function automatic int eff_w(input int p, input int w);
    int pe = eff_p(p);
    if (w == 0) return 1;
    if (w >= pe) return pe - 1;
    return w;
  endfunction

  task automatic sample();
    @(posedge clk);
    #1;
  endtask

  task automatic go_idle();
    @(negedge clk);
    run_en = 1'b0;
    sample();
    sample();
  endtask

  // Start a train from idle with (p0,w0). After the first sample, switch the
  // inputs to (p1,w1). The expected waveform follows the first settings until
  // the second rising edge and the new settings after that.
  task automatic run_seq(input int p0, input int w0, input int p1, input int w1,
                         input int n, input string tag);
    int pa = eff_p(p0);
    int wa = eff_w(p0, w0);
    int pb = eff_p(p1);
    int wb = eff_w(p1, w1);
    go_idle();
    @(negedge clk);
    period_cyc = CNT_W'(p0);
    width_cyc  = CNT_W'(w0);
    run_en     = 1'b1;
    for (int i = 0; i < n; i++) begin
      int ph;
      int wc;
      sample();
      if (i < pa) begin ph = i;             wc = wa; end
      else        begin ph = (i - pa) % pb; wc = wb; end
      if (i == 0) begin
        chk(pulse_out && rise_stb, {tag, " R2 first edge"}, int'(pulse_out), 1);
      end
      chk(pulse_out == (ph < wc), {tag, " R4 level"}, int'(pulse_out), int'(ph < wc));
      chk(rise_stb == (ph == 0), {tag, " R3/R6 rise_stb"}, int'(rise_stb), int'(ph == 0));
      chk(fall_stb == (ph == wc), {tag, " R5 fall_stb"}, int'(fall_stb), int'(ph == wc));
      if (i == 0) begin
        @(negedge clk);
        period_cyc = CNT_W'(p1);
        width_cyc  = CNT_W'(w1);
      end
    end
  endtask

  task automatic t_reset();
    chk(!pulse_out && !rise_stb && !fall_stb, "R1 during reset", int'(pulse_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    sample();
    chk(!pulse_out && !rise_stb && !fall_stb, "R1 after reset", int'(pulse_out), 0);
  endtask

  task automatic t_basic();
    run_seq(5, 2, 5, 2, 16, "basic");
    run_seq(7, 6, 7, 6, 22, "wide");
    run_seq(3, 1, 3, 1, 10, "narrow");
  endtask

  task automatic t_width_clamp();
    run_seq(4, 0, 4, 0, 13, "R7 width0");
    run_seq(4, 10, 4, 10, 13, "R7 width_big");
    run_seq(6, 6, 6, 6, 19, "R7 width_eq");
  endtask

  task automatic t_period_clamp();
    run_seq(0, 5, 0, 5, 9, "R8 period0");
    run_seq(1, 1, 1, 1, 9, "R8 period1");
  endtask

  task automatic t_midchange();
    run_seq(6, 2, 8, 4, 30, "R9 grow");
    run_seq(9, 5, 4, 1, 25, "R9 shrink");
  endtask

  task automatic t_disable();
    go_idle();
    @(negedge clk);
    period_cyc = CNT_W'(6);
    width_cyc  = CNT_W'(4);
    run_en     = 1'b1;
    sample();
    sample();
    chk(pulse_out == 1'b1, "R10 high before drop", int'(pulse_out), 1);
    @(negedge clk);
    run_en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      sample();
      chk(!pulse_out && !rise_stb && !fall_stb, "R10 held low",
          int'({pulse_out, rise_stb, fall_stb}), 0);
    end
    @(negedge clk);
    run_en = 1'b1;
    sample();
    chk(pulse_out && rise_stb, "R10 restart edge", int'(rise_stb), 1);
    for (int i = 1; i < 12; i++) begin
      sample();
      chk(pulse_out == ((i % 6) < 4), "R10 restart level", int'(pulse_out), int'((i % 6) < 4));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_basic();
    t_width_clamp();
    t_period_clamp();
    t_midchange();
    t_disable();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule